// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block walks a chain of command packets kept in a word-organised memory and streams the payload of every packet to a downstream command consumer. Each packet begins with a single header word that carries both its payload length and the address of the packet that follows it. The walker reads a header, forwards the payload words that sit directly behind it, and then follows the next pointer. It stops when a next pointer carries the termination flag. The all-ones end value also carries that flag.

A chain that points back into itself would otherwise never end. To prevent this, the walker flags every header it visits by setting one bit of the header in memory. Meeting an already flagged header ends the walk. When the walk is over, a second pass starts again from the first packet, follows the same number of links and removes the flags. Only then does the block report completion. The block is started by a one-cycle pulse with a start address. It drives a single-port memory master with a read latency of one cycle and a ready/valid payload stream.

Top module: `llw_chain_walker`

## Requirements
- R1: The start address is reduced to its low 24 bits. If those bits are all ones, no memory access is made and `done` is high in the cycle after the start pulse.
- R2: A node address is a byte address. The memory word index is node bits 20:2, and bits 23:21 are ignored. In a header, bits 31:24 hold the payload length and bits 23:0 hold the next node address.
- R3: The payload words are the words that directly follow the header, read in ascending order. They leave on `pay_data`/`pay_valid`. A word stays stable until `pay_ready` accepts it.
- R4: A header with length 0 forwards no payload word, and the walk goes straight on to its next pointer.
- R5: After forwarding a node's payload, the walk continues at the next address unless bit 23 of that next address is set. The all-ones end marker is one such value.
- R6: When a visited header has bit 23 clear, the walker writes it back during the walk with bit 23 set. Every memory write changes only bit 23 of the word just read from that address.
- R7: When the chain leads back to a node visited earlier, that node's payload is forwarded once more. The walk then stops because its flagged header holds a next field with bit 23 set.
- R8: After the walk, every visited header has bit 23 clear, except a header whose next field is the all-ones end marker, which is left untouched. The cleanup follows exactly as many links as the walk visited, masking each pointer to 21 bits.
- R9: `done` is a single-cycle pulse raised after the cleanup pass has finished. A start pulse while a walk or cleanup is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a walk |
| start_addr | input | 32 | Byte address of the first node (upper bits discarded) |
| done | output | 1 | One-cycle pulse when walk and cleanup are complete |
| mem_rd_en | output | 1 | Memory read request; data returns on the next cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 19 | Memory word index for read or write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd_en` |
| pay_valid | output | 1 | Payload word available |
| pay_data | output | 32 | Payload word |
| pay_ready | input | 1 | Consumer accepts the payload word |

## Verification
Three events land in the single cycle in which a header arrives from memory: the flag write-back for that header, the decision whether the walk must stop, and the latching of the length that controls payload forwarding. A node that points to itself makes all three coincide on a header that already carries the flag. The bench provokes this with self-loops, two-node loops and headers that are flagged in advance. It judges the result by the forwarded sequence (the closing node appears once more), by the number of flag-set and flag-clear writes seen on the memory port, and by comparing the memory against a bench-side model after `done`.

// File: rtl/llw_pkg.sv
package llw_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HDR_RD,
      ST_HDR_CAP,
      ST_PAY_RD,
      ST_PAY_CAP,
      ST_PAY_OUT,
      ST_ADV,
      ST_CLN_RD,
      ST_CLN_CAP,
      ST_DONE
   } llw_state_e;

endpackage

// File: rtl/llw_hdr_decode.sv
// Splits a header word into its fields and forms the flagged / unflagged
// write-back values for both passes.
module llw_hdr_decode #(
   parameter int DATA_W       = 32,
   parameter int NODE_AW      = 24,
   parameter int IDX_W        = 21,
   parameter int LEN_LSB      = 24,
   parameter int MARK_BIT     = 23,
   parameter bit KEEP_END_HDR = 1'b1,
   localparam int LEN_W  = DATA_W - LEN_LSB,
   localparam int MEM_AW = IDX_W - 2
) (
   input  logic [DATA_W-1:0] hdr,
   output logic [LEN_W-1:0]  len,
   output logic [MEM_AW-1:0] next_word,
   output logic              stop,
   output logic              mark_need,
   output logic [DATA_W-1:0] mark_word,
   output logic              clean_need,
   output logic [DATA_W-1:0] clean_word
);
   localparam logic [DATA_W-1:0]  MARK_MASK = DATA_W'(1) << MARK_BIT;
   localparam logic [NODE_AW-1:0] END_ADDR  = '1;

   logic [NODE_AW-1:0] next_full;
   logic               is_end;
   logic [1:0]         unused_lsb;

   assign len        = hdr[DATA_W-1:LEN_LSB];
   assign next_full  = hdr[NODE_AW-1:0];
   assign next_word  = next_full[IDX_W-1:2];
   assign unused_lsb = next_full[1:0];
   assign is_end     = (next_full == END_ADDR);
   assign stop       = hdr[MARK_BIT];
   assign mark_need  = ~hdr[MARK_BIT];
   assign mark_word  = hdr | MARK_MASK;
   assign clean_word = hdr & ~MARK_MASK;

   generate
      if (KEEP_END_HDR) begin : g_keep_end
         assign clean_need = hdr[MARK_BIT] & ~is_end;
      end else begin : g_clear_all
         logic unused_end;
         assign unused_end = is_end;
         assign clean_need = hdr[MARK_BIT];
      end
   endgenerate

endmodule

// File: rtl/llw_node_cnt.sv
// Visited-node counter: counts up during the walk, down during cleanup.
module llw_node_cnt #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] count,
   output logic             last
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         count <= '0;
      end else if (inc) begin
         count <= count + CNT_W'(1);
      end else if (dec) begin
         count <= count - CNT_W'(1);
      end
   end

   assign last = (count == CNT_W'(1));

   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> (count != '1));                                  // R8
   AST_CNT_NO_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (count != '0));                                  // R8
   AST_CNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc && dec));                                          // R8

endmodule

// File: rtl/llw_pay_stage.sv
// Output register for the payload stream with a ready/valid handshake.
module llw_pay_stage #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              fire
);
   assign fire = out_valid & out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_data  <= load_data;
      end else if (fire) begin
         out_valid <= 1'b0;
      end
   end

   AST_PAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));   // R3
   AST_PAY_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !out_valid);                                             // R3

endmodule

// File: rtl/llw_chain_walker.sv
module llw_chain_walker #(
   parameter int DATA_W       = 32,
   parameter int NODE_AW      = 24,
   parameter int IDX_W        = 21,
   parameter int LEN_LSB      = 24,
   parameter int MARK_BIT     = 23,
   parameter bit KEEP_END_HDR = 1'b1,
   localparam int LEN_W  = DATA_W - LEN_LSB,
   localparam int MEM_AW = IDX_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] start_addr,
   output logic              done,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              pay_valid,
   output logic [DATA_W-1:0] pay_data,
   input  logic              pay_ready
);
   import llw_pkg::*;

   localparam int CNT_W = MEM_AW + 1;
   localparam logic [NODE_AW-1:0] END_ADDR  = '1;
   localparam logic [DATA_W-1:0]  MARK_MASK = DATA_W'(1) << MARK_BIT;

   generate
      if (LEN_LSB + LEN_W != DATA_W || LEN_LSB < NODE_AW) begin : g_bad_fields
         $error("llw_chain_walker: length field overlaps next pointer");
      end
      if (MARK_BIT >= NODE_AW || MARK_BIT < IDX_W) begin : g_bad_mark
         $error("llw_chain_walker: flag bit must lie above the memory index");
      end
      if (IDX_W < 3 || NODE_AW > DATA_W) begin : g_bad_width
         $error("llw_chain_walker: address widths out of range");
      end
   endgenerate

   llw_state_e        state;
   logic [MEM_AW-1:0] cur_w;
   logic [MEM_AW-1:0] base_w;
   logic [MEM_AW-1:0] next_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  idx;
   logic              stop_q;

   logic [LEN_W-1:0]  d_len;
   logic [MEM_AW-1:0] d_next;
   logic              d_stop;
   logic              d_mark_need;
   logic [DATA_W-1:0] d_mark_word;
   logic              d_clean_need;
   logic [DATA_W-1:0] d_clean_word;

   logic              cnt_clr;
   logic              cnt_inc;
   logic              cnt_dec;
   logic [CNT_W-1:0]  cnt_val;
   logic              cnt_last;

   logic              pay_load;
   logic              pay_fire;
   logic [MEM_AW-1:0] pay_addr;

   logic              start_is_end;
   logic              unused_start;

   assign start_is_end = (start_addr[NODE_AW-1:0] == END_ADDR);
   assign unused_start = ^start_addr[DATA_W-1:NODE_AW];

   llw_hdr_decode #(
      .DATA_W      (DATA_W),
      .NODE_AW     (NODE_AW),
      .IDX_W       (IDX_W),
      .LEN_LSB     (LEN_LSB),
      .MARK_BIT    (MARK_BIT),
      .KEEP_END_HDR(KEEP_END_HDR)
   ) u_dec (
      .hdr       (mem_rdata),
      .len       (d_len),
      .next_word (d_next),
      .stop      (d_stop),
      .mark_need (d_mark_need),
      .mark_word (d_mark_word),
      .clean_need(d_clean_need),
      .clean_word(d_clean_word)
   );

   llw_node_cnt #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cnt_clr),
      .inc  (cnt_inc),
      .dec  (cnt_dec),
      .count(cnt_val),
      .last (cnt_last)
   );

   llw_pay_stage #(
      .DATA_W(DATA_W)
   ) u_pay (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (pay_load),
      .load_data(mem_rdata),
      .out_ready(pay_ready),
      .out_valid(pay_valid),
      .out_data (pay_data),
      .fire     (pay_fire)
   );

   // Control decodes
   assign cnt_clr  = (state == ST_IDLE) && start;
   assign cnt_inc  = (state == ST_HDR_CAP);
   assign cnt_dec  = (state == ST_CLN_CAP);
   assign pay_load = (state == ST_PAY_CAP);
   assign pay_addr = cur_w + MEM_AW'(1) + MEM_AW'(idx);
   assign done     = (state == ST_DONE);

   always_comb begin
      mem_rd_en = 1'b0;
      mem_wr_en = 1'b0;
      mem_addr  = cur_w;
      mem_wdata = d_mark_word;
      unique case (state)
         ST_HDR_RD:  mem_rd_en = 1'b1;
         ST_CLN_RD:  mem_rd_en = 1'b1;
         ST_PAY_RD: begin
            mem_rd_en = 1'b1;
            mem_addr  = pay_addr;
         end
         ST_HDR_CAP: mem_wr_en = d_mark_need;
         ST_CLN_CAP: begin
            mem_wr_en = d_clean_need;
            mem_wdata = d_clean_word;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cur_w  <= '0;
         base_w <= '0;
         next_q <= '0;
         len_q  <= '0;
         idx    <= '0;
         stop_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  cur_w  <= start_addr[IDX_W-1:2];
                  base_w <= start_addr[IDX_W-1:2];
                  state  <= start_is_end ? ST_DONE : ST_HDR_RD;
               end
            end
            ST_HDR_RD: state <= ST_HDR_CAP;
            ST_HDR_CAP: begin
               len_q  <= d_len;
               next_q <= d_next;
               stop_q <= d_stop;
               idx    <= '0;
               state  <= (d_len != '0) ? ST_PAY_RD : ST_ADV;
            end
            ST_PAY_RD:  state <= ST_PAY_CAP;
            ST_PAY_CAP: state <= ST_PAY_OUT;
            ST_PAY_OUT: begin
               if (pay_fire) begin
                  if (idx == len_q - LEN_W'(1)) begin
                     state <= ST_ADV;
                  end else begin
                     idx   <= idx + LEN_W'(1);
                     state <= ST_PAY_RD;
                  end
               end
            end
            ST_ADV: begin
               if (stop_q) begin
                  cur_w <= base_w;
                  state <= ST_CLN_RD;
               end else begin
                  cur_w <= next_q;
                  state <= ST_HDR_RD;
               end
            end
            ST_CLN_RD: state <= ST_CLN_CAP;
            ST_CLN_CAP: begin
               cur_w <= d_next;
               state <= cnt_last ? ST_DONE : ST_CLN_RD;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                       // R9
   AST_WR_ONLY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ((mem_wdata ^ mem_rdata) == MARK_MASK));                 // R6
   AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ($past(mem_rd_en) && mem_addr == $past(mem_addr)));      // R2
   AST_NO_PAY_IN_CLEANUP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CLN_CAP) |-> !pay_valid);                                 // R8

endmodule

// File: tb/llw_chain_walker_tb.sv
`timescale 1ns/1ps
module llw_chain_walker_tb;

   localparam int MW = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] start_addr = '0;
   logic        done;
   logic        mem_rd_en, mem_wr_en;
   logic [18:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        pay_valid;
   logic [31:0] pay_data;
   logic        pay_ready = 1'b0;

   always #5 clk = ~clk;

   llw_chain_walker u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_addr(start_addr),
      .done      (done),
      .mem_rd_en (mem_rd_en),
      .mem_wr_en (mem_wr_en),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .pay_valid (pay_valid),
      .pay_data  (pay_data),
      .pay_ready (pay_ready)
   );

   // memory model, one-cycle read latency
   logic [31:0] mem [0:MW-1];
   logic        tb_we = 1'b0;
   logic [9:0]  tb_wa = '0;
   logic [31:0] tb_wd = '0;

   always @(posedge clk) begin
      if (tb_we) mem[tb_wa] <= tb_wd;
      else if (mem_wr_en) mem[mem_addr[9:0]] <= mem_wdata;
      if (mem_rd_en) mem_rdata <= mem[mem_addr[9:0]];
   end

   // monitor
   int          rmode = 0;
   int          cyc = 0;
   int          n_mark = 0, n_clr = 0, n_rd = 0, n_hi = 0, n_done = 0, n_dbl = 0;
   logic        done_prev = 1'b0;
   logic [31:0] got_q [$];

   always @(negedge clk) begin
      cyc = cyc + 1;
      case (rmode)
         0: pay_ready = 1'b1;
         1: pay_ready = (cyc % 3) != 0;
         default: pay_ready = (cyc % 5) < 2;
      endcase
      if (pay_valid && pay_ready) got_q.push_back(pay_data);
      if (mem_wr_en) begin
         if (mem_wdata[23]) n_mark = n_mark + 1;
         else n_clr = n_clr + 1;
      end
      if (mem_rd_en) n_rd = n_rd + 1;
      if ((mem_rd_en || mem_wr_en) && mem_addr[18:10] != '0) n_hi = n_hi + 1;
      if (done) begin
         n_done = n_done + 1;
         if (done_prev) n_dbl = n_dbl + 1;
      end
      done_prev = done;
   end

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL R9 watchdog: actual 0 expected 1");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic poke(input int w, input logic [31:0] v);
      @(negedge clk);
      tb_we = 1'b1;
      tb_wa = 10'(w);
      tb_wd = v;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   function automatic logic [23:0] node_addr(input int w);
      return 24'h600000 | 24'(w << 2);
   endfunction

   // chain of n nodes at words w0+8k; lenpat shifts lengths;
   // loop_to >= 0 closes the chain back onto that node; premark sets bit 23
   task automatic build(input int w0, input int n, input int lenpat,
                        input int loop_to, input int premark);
      for (int k = 0; k < n; k++) begin
         int w = w0 + 8 * k;
         int l = (lenpat + k) % 4;
         logic [23:0] nx;
         if (k == n - 1) nx = (loop_to >= 0) ? node_addr(w0 + 8 * loop_to) : 24'hFFFFFF;
         else nx = node_addr(w0 + 8 * (k + 1));
         if (premark == k) nx = nx | 24'h800000;
         poke(w, {8'(l), nx});
         for (int i = 0; i < 7; i++)
            poke(w + 1 + i, {8'(k), 8'(i), 16'(w0)} ^ 32'h5A3C0000);
      end
   endtask

   task automatic run_walk(input logic [31:0] saddr, input int mode,
                           input int lo, input int hi, input bit inject,
                           input string name);
      logic [31:0] sh [0:MW-1];
      logic [31:0] exp_q [$];
      logic [23:0] a;
      int visits, emark, eclr, gsz, m0, c0, d0, db0, h0, wcnt, bad;
      for (int i = 0; i < MW; i++) sh[i] = mem[i];
      // expected walk from the requirements
      a = saddr[23:0];
      visits = 0; emark = 0; eclr = 0;
      while (a != 24'hFFFFFF) begin
         int w = int'(a[20:2]) % MW;
         logic [31:0] h = sh[w];
         if (!h[23]) begin emark++; sh[w] = h | 32'h00800000; end
         for (int i = 0; i < int'(h[31:24]); i++) exp_q.push_back(sh[(w + 1 + i) % MW]);
         visits++;
         a = h[23:0];
         if (a[23]) break;
      end
      a = saddr[23:0];
      for (int v = 0; v < visits; v++) begin
         int w = int'(a[20:2]) % MW;
         logic [31:0] h = sh[w];
         if (h[23] && h[23:0] != 24'hFFFFFF) begin eclr++; sh[w] = h & ~32'h00800000; end
         a = {3'b000, h[20:0]};
      end
      gsz = got_q.size(); m0 = n_mark; c0 = n_clr; d0 = n_done; db0 = n_dbl; h0 = n_hi;
      rmode = mode;
      @(negedge clk);
      start = 1'b1; start_addr = saddr;
      @(negedge clk);
      start = 1'b0;
      if (inject) begin
         repeat (6) @(negedge clk);
         start = 1'b1; start_addr = 32'h0000_0010;
         @(negedge clk);
         start = 1'b0;
      end
      wcnt = 0;
      while (n_done == d0 && wcnt < 5000) begin @(negedge clk); wcnt++; end
      @(negedge clk);
      chk(n_done - d0 == 1 && n_dbl == db0, "R9", {name, " single done pulse"},
          n_done - d0, 1);
      chk(got_q.size() - gsz == exp_q.size(), "R3/R4/R5/R7", {name, " payload count"},
          got_q.size() - gsz, exp_q.size());
      bad = 0;
      for (int i = 0; i < exp_q.size() && gsz + i < got_q.size(); i++)
         if (got_q[gsz + i] !== exp_q[i]) bad++;
      chk(bad == 0, "R3/R5/R7", {name, " payload order"}, bad, 0);
      chk(n_mark - m0 == emark, "R6", {name, " flag-set writes"}, n_mark - m0, emark);
      chk(n_clr - c0 == eclr, "R8", {name, " flag-clear writes"}, n_clr - c0, eclr);
      bad = 0;
      for (int i = lo; i < hi; i++) if (mem[i] !== sh[i]) bad++;
      chk(bad == 0, "R8", {name, " memory after cleanup"}, bad, 0);
      chk(n_hi == h0, "R2", {name, " word index bits 18:10"}, n_hi - h0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      chk(!done && !pay_valid && !mem_rd_en && !mem_wr_en, "R9", "reset outputs quiet",
          {done, pay_valid, mem_rd_en, mem_wr_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // dummy node at word 4 used only if a mid-walk start were accepted
      poke(4, {8'd2, 24'hFFFFFF});
      poke(5, 32'hDEAD0001);
      poke(6, 32'hDEAD0002);

      // R1: end address with junk upper byte
      begin
         int r0 = n_rd;
         @(negedge clk);
         start = 1'b1; start_addr = 32'hAB_FFFFFF;
         @(negedge clk);
         start = 1'b0;
         chk(done === 1'b1, "R1", "done one cycle after end-address start", done, 1);
         chk(n_rd == r0, "R1", "no reads for end address", n_rd - r0, 0);
         @(negedge clk);
      end

      // sweep: chain lengths, length patterns (incl. 0 -> R4), stall patterns
      begin
         int walk = 0;
         for (int n = 1; n <= 4; n++)
            for (int lp = 0; lp < 4; lp++)
               for (int md = 0; md < 3; md++) begin
                  int w0 = 16 + (walk % 24) * 40;
                  build(w0, n, lp, -1, -1);
                  run_walk(32'hA5000000 | {8'h00, node_addr(w0)}, md, w0, w0 + 8 * n, 1'b0,
                           $sformatf("chain n=%0d lp=%0d md=%0d", n, lp, md));
                  walk++;
               end
      end

      // R7: two-node loop and self loop
      build(200, 2, 1, 0, -1);
      run_walk({8'h00, node_addr(200)}, 1, 200, 216, 1'b0, "R7 two-node loop");
      build(300, 1, 2, 0, -1);
      run_walk({8'h00, node_addr(300)}, 2, 300, 308, 1'b0, "R7 self loop");
      build(400, 3, 3, 0, -1);
      run_walk({8'h00, node_addr(408)}, 0, 400, 424, 1'b0, "R7 loop entered mid-chain");

      // R5/R8: header already carrying the flag ends the walk after it
      build(500, 3, 1, -1, 0);
      run_walk({8'h00, node_addr(500)}, 0, 500, 524, 1'b0, "R5 pre-flagged header");

      // R9: start pulse during a walk is ignored
      build(600, 4, 3, -1, -1);
      run_walk({8'h00, node_addr(600)}, 1, 600, 632, 1'b1, "R9 mid-walk start ignored");

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule